// File: doc/BRIEF.md
# Handshaked Byte Exchange Port

A small memory-mapped port that swaps one byte with the outside world per accepted data write. A bus master writes a byte to the data location. If the previous exchange has been acknowledged, the byte is driven onto an outgoing latch (for example, an indicator lamp driver). In the same cycle, the byte currently presented on the key input is captured into the data location. A completion flag in the status location then sets.

The master acknowledges the completion by reading the status location; that read clears the flag. A data write made while the flag is still set is not exchanged. It only overwrites the data location. There is no bit-serial shifting: an accepted exchange completes in one clock cycle. The control location is plain storage for the mode bits and does not alter the exchange.

Top module: `byte_xchg_port`

## Requirements
- R1: After reset, the control, status and data locations read 0x00 and the outgoing latch `led_byte` is 0x00.
- R2: Offset 0 is an 8-bit read/write control location (bit 7 interrupt enable, bit 6 port enable, bit 5 open-drain option, bit 4 master select, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate). A write is read back unchanged, and writing it does not change the completion flag.
- R3: A write to offset 2 while the completion flag is clear updates three things on the next clock edge: `led_byte` takes the written byte, the data location takes the `key_byte` value sampled on that edge, and the completion flag (status bit 7, value 0x80) sets.
- R4: A write to offset 2 while the completion flag is set stores the written byte in the data location only. `led_byte` is unchanged and the flag stays set.
- R5: A read of offset 1 returns the status value, with the flag in bit 7 and the collision (bit 6) and fault (bit 4) bits always 0. The flag is clear from the following cycle.
- R6: A read of offset 2 returns the data location and changes neither the data location nor the flag.
- R7: Writes to offset 1 are ignored.
- R8: `led_byte` holds its value through every cycle without an accepted exchange.
- R9: `bus_rdata` is 0x00 in cycles without a read strobe, and offset 3 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | Location offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| key_byte | input | 8 | Incoming byte captured on an accepted exchange |
| led_byte | output | 8 | Outgoing latch loaded on an accepted exchange |

## Verification
The bench exchanges several distinct byte pairs in which the written byte and the key byte always differ. A swapped or missing path between the latch and the data location therefore shows up as a wrong value. Data writes with no status read in between separate the blocked path from the accepted one, because the latch must keep the old byte while the data location takes the new one. Repeated status and data reads show that only the status read clears the flag. Writes to offsets 1 and 3, and to the control location between exchanges, show that these accesses leave the exchange state unchanged.

// File: rtl/byte_xchg_port.sv
module byte_xchg_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] key_byte,
  output logic [DW-1:0] led_byte
);
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;
  localparam int DONE_BIT = DW - 1;

  logic [DW-1:0] ctrl_q, data_q, led_q;
  logic          done_q;
  logic          rd_acc, wr_ctrl, wr_data, rd_stat, xchg_ok;
  logic [DW-1:0] stat_val;

  assign rd_acc   = bus_rd & ~bus_wr;
  assign wr_ctrl  = bus_wr & (bus_addr == OFS_CTRL);
  assign wr_data  = bus_wr & (bus_addr == OFS_DATA);
  assign rd_stat  = rd_acc & (bus_addr == OFS_STAT);
  assign xchg_ok  = wr_data & ~done_q;
  assign stat_val = {done_q, {(DW-1){1'b0}}};
  assign led_byte = led_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      led_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (xchg_ok) begin
        led_q  <= bus_wdata;
        data_q <= key_byte;
        done_q <= 1'b1;
      end else if (wr_data) begin
        data_q <= bus_wdata;
      end else if (rd_stat) begin
        done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      unique case (bus_addr)
        OFS_CTRL: bus_rdata = ctrl_q;
        OFS_STAT: bus_rdata = stat_val;
        OFS_DATA: bus_rdata = data_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_XCHG_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == OFS_DATA && !done_q) |=> (led_byte == $past(bus_wdata) && data_q == $past(key_byte) && done_q)); // R3
  AST_BLOCKED_KEEPS_LED: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == OFS_DATA && done_q) |=> ($stable(led_byte) && done_q && data_q == $past(bus_wdata))); // R4
  AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && !bus_wr && bus_addr == OFS_STAT) |=> !done_q); // R5
  AST_DATA_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && !bus_wr && bus_addr == OFS_DATA) |=> ($stable(data_q) && $stable(done_q))); // R6
  AST_LED_HELD: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_addr == OFS_DATA && !done_q) |=> $stable(led_byte)); // R8
  AST_FLAG_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_q) |-> $past(bus_wr && bus_addr == OFS_DATA)); // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |-> bus_rdata == '0); // R9
  AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && !bus_wr && bus_addr == OFS_STAT) |-> bus_rdata[DW-2:0] == '0); // R5
endmodule

// File: tb/tb_byte_xchg_port.sv
module tb_byte_xchg_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, key_byte = 0;
  logic [7:0] bus_rdata, led_byte;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_ctrl = 0, m_data = 0, m_led = 0;
  bit         m_flag = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  byte_xchg_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_byte(key_byte), .led_byte(led_byte)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
    case (a)
      2'd0: m_ctrl = d;
      2'd2: if (!m_flag) begin m_led = d; m_data = key_byte; m_flag = 1; end
            else m_data = d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [1:0] a, input string tag);
    logic [7:0] e;
    case (a)
      2'd0: e = m_ctrl;
      2'd1: e = {m_flag, 7'b0};
      2'd2: e = m_data;
      default: e = 8'h00;
    endcase
    @(posedge clk); #1;
    bus_rd = 1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 0;
    if (a == 2'd1) m_flag = 0;
  endtask

  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata, e, t);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(led_byte, 8'h00, "R1 led after reset");
    bus_read(2'd0, "R1 ctrl after reset");
    bus_read(2'd1, "R1 status after reset");
    bus_read(2'd2, "R1 data after reset");
    @(negedge clk);
    chk(bus_rdata, 8'h00, "R9 idle rdata");

    bus_write(2'd0, 8'hA5);
    bus_read(2'd0, "R2 ctrl readback");
    bus_read(2'd1, "R2 ctrl leaves flag");

    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, "R7 status write ignored");

    key_byte = 8'h3C;
    bus_write(2'd2, 8'h81);
    chk(led_byte, 8'h81, "R3 led loaded");
    bus_read(2'd2, "R3 key captured");
    bus_read(2'd2, "R6 data read repeat");
    bus_read(2'd1, "R5 status shows flag");
    bus_read(2'd1, "R5 flag cleared");

    key_byte = 8'h5A;
    bus_write(2'd2, 8'h7E);
    chk(led_byte, 8'h7E, "R3 second exchange led");
    key_byte = 8'h99;
    bus_write(2'd2, 8'h11);
    chk(led_byte, 8'h7E, "R4 blocked write keeps led");
    bus_read(2'd2, "R4 blocked write stores byte");
    bus_read(2'd1, "R4 flag still set");

    bus_write(2'd3, 8'hEE);
    bus_read(2'd3, "R9 offset 3 reads zero");
    bus_write(2'd0, 8'h0F);
    repeat (4) @(posedge clk);
    #1 chk(led_byte, 8'h7E, "R8 led held while idle");

    for (int i = 0; i < 6; i++) begin
      key_byte = 8'(8'h10 * i + 8'h07);
      bus_write(2'd2, 8'(8'hC3 ^ (i * 8'h1D)));
      chk(led_byte, m_led, "R3 pattern led");
      bus_read(2'd2, "R3 pattern key");
      bus_read(2'd1, "R5 pattern status");
    end

    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule